// File: doc/BRIEF.md
# Pipelined Block Transfer Master

This block is a bus master that moves a block of words over a Wishbone bus in pipelined mode. A single command gives the start address, the direction, the byte-select mask and the number of phases. The master then presents one address phase per clock. It does not wait for the acknowledge of earlier phases. Each phase targets the next word address.

The slave can hold off a phase by raising its stall input. The master then repeats that phase unchanged on the following clock. Issuing requests and collecting acknowledges are handled by separate logic. An outstanding-request counter joins the two. That counter also enforces a parameterized cap on unacknowledged requests.

The bus cycle stays open until every accepted request has been acknowledged. At that point the master closes the cycle and raises a one-clock completion pulse. Write data is pulled from the client one word per phase through a take strobe. Read data is returned to the client with a valid flag, in issue order.

Top module: `blk_pipe_master`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o`, `done`, `wr_take` and `rd_valid` are low and `cmd_ready` is high.
- R2: A command with a nonzero count that is taken while `cmd_ready` is high makes `wb_cyc_o` and `wb_stb_o` rise together on the next clock. On that clock the bus also carries the start address, the commanded `wb_sel_o`, and `wb_we_o` (1 for write, 0 for read).
- R3: A phase is accepted in a clock where `wb_stb_o` is high and `wb_stall_i` is low. The next phase, at address +1, is presented on the following clock without waiting for any acknowledge.
- R4: While `wb_stb_o` and `wb_stall_i` are both high, the next clock shows the same address, write data, `wb_we_o` and `wb_sel_o`. The stalled phase is not counted as accepted.
- R5: Exactly `cmd_count` phases are accepted. `wb_stb_o` goes low after the clock in which the last one is accepted.
- R6: `wb_cyc_o` stays high until the acknowledge of the final outstanding request has been received. It falls on the clock right after that acknowledge. `cmd_ready` equals the inverse of `wb_cyc_o`.
- R7: For reads, each clock with `wb_ack_i` high produces, one clock later, `rd_valid` high with `rd_data` equal to the `wb_dat_i` value seen with that acknowledge, in issue order.
- R8: The count of accepted but unacknowledged requests never exceeds `MAX_OUT`. `wb_stb_o` is low whenever that count has reached `MAX_OUT`.
- R9: `done` is high for exactly the one clock in which `wb_cyc_o` has just fallen.
- R10: For writes, `wr_take` is high in the clock where the master loads `wr_data` into a new phase (command start, or acceptance of a phase that is not the last). `wb_dat_o` of each phase equals the word supplied at its load.
- R11: A command with a count of zero starts no bus cycle: `wb_cyc_o` and `wb_stb_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Master idle, command may be taken |
| cmd_addr | input | AW | Word address of the first phase |
| cmd_write | input | 1 | 1 = block write, 0 = block read |
| cmd_sel | input | DW/8 | Byte-select mask for every phase |
| cmd_count | input | CW | Number of phases |
| wr_data | input | DW | Write word for the phase being loaded |
| wr_take | output | 1 | `wr_data` is loaded at this clock edge |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DW | Read word |
| done | output | 1 | One-clock pulse when the bus cycle ends |
| wb_adr_o | output | AW | Bus address |
| wb_dat_o | output | DW | Bus write data |
| wb_we_o | output | 1 | Bus write enable |
| wb_sel_o | output | DW/8 | Bus byte selects |
| wb_stb_o | output | 1 | Bus strobe |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_dat_i | input | DW | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |
| wb_stall_i | input | 1 | Bus stall |

## Verification
The bench builds the block with `MAX_OUT` = 3, a 5-bit count, a 16-bit address and 32-bit data. With these values a block longer than three phases, paired with a slow-acknowledging slave, drives the outstanding count against its cap. That exercises strobe suppression and re-issue after the acknowledges drain. The short count width keeps random blocks brief, so many commands, including single-phase and zero-length ones, fit in one run. The slave model mixes random stalls with random acknowledge delays, which also produces clocks where an acceptance and an acknowledge coincide.

// File: rtl/bm_pkg.sv
package bm_pkg;
   typedef enum logic {
      BM_READ  = 1'b0,
      BM_WRITE = 1'b1
   } bm_dir_e;
endpackage

// File: rtl/bm_issue.sv
module bm_issue #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int SW = 4,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] cmd_addr,
   input  logic          cmd_write,
   input  logic [SW-1:0] cmd_sel,
   input  logic [CW-1:0] cmd_count,
   input  logic [DW-1:0] wr_data,
   input  logic          stall_i,
   input  logic          room,
   output logic          stb_o,
   output logic [AW-1:0] adr_o,
   output logic [DW-1:0] dat_o,
   output logic          we_o,
   output logic [SW-1:0] sel_o,
   output logic          accept,
   output logic          all_issued,
   output logic          wr_take
);
   import bm_pkg::*;

   logic [CW-1:0] rem_q;
   logic [CW-1:0] rem_after;
   logic          more;

   assign accept     = stb_o & ~stall_i;
   assign rem_after  = rem_q - CW'(accept);
   assign more       = (rem_after != '0);
   assign all_issued = ~more;
   assign wr_take    = (start & (cmd_write == BM_WRITE)) | (accept & we_o & more);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         stb_o <= 1'b0;
         adr_o <= '0;
         dat_o <= '0;
         we_o  <= 1'b0;
         sel_o <= '0;
      end else if (start) begin
         rem_q <= cmd_count;
         stb_o <= 1'b1;
         adr_o <= cmd_addr;
         dat_o <= wr_data;
         we_o  <= cmd_write;
         sel_o <= cmd_sel;
      end else begin
         rem_q <= rem_after;
         if (accept && more) begin
            adr_o <= adr_o + AW'(1);
            if (we_o) dat_o <= wr_data;
         end
         if (!(stb_o && stall_i)) stb_o <= more & room;
      end
   end

   p_stall_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o && stall_i && !start) |=> (stb_o && $stable(adr_o) && $stable(dat_o)
                                        && $stable(we_o) && $stable(sel_o)));

   p_addr_moves_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o && !stall_i && more && !start) |=> (adr_o == $past(adr_o) + AW'(1)));
endmodule

// File: rtl/bm_track.sv
module bm_track #(
   parameter int MAX_OUT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic accept,
   input  logic ack_i,
   input  logic all_issued,
   output logic room,
   output logic ack_ok,
   output logic cyc_o,
   output logic done_o
);
   localparam int OW = $clog2(MAX_OUT + 1);
   localparam logic [OW-1:0] CAP = OW'(MAX_OUT);

   logic [OW-1:0] out_q;
   logic [OW-1:0] out_next;

   assign ack_ok   = ack_i & cyc_o & (out_q != '0);
   assign out_next = out_q + OW'(accept) - OW'(ack_ok);
   assign room     = (out_next < CAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q  <= '0;
         cyc_o  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         out_q  <= out_next;
         done_o <= 1'b0;
         if (start) begin
            cyc_o <= 1'b1;
         end else if (cyc_o && all_issued && out_next == '0) begin
            cyc_o  <= 1'b0;
            done_o <= 1'b1;
         end
      end
   end

   p_out_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_q <= CAP);

   p_cyc_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_o && out_q != '0 && !(ack_i && out_q == OW'(1))) |=> cyc_o);

   p_done_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!cyc_o && $past(cyc_o)));
endmodule

// File: rtl/bm_rdcap.sv
module bm_rdcap #(
   parameter int DW      = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ack_ok,
   input  logic          we,
   input  logic [DW-1:0] dat_i,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);
   logic hit;
   assign hit = ack_ok & ~we;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
         end else begin
            rd_valid <= hit;
            if (hit) rd_data <= dat_i;
         end
      end
      p_rd_follows_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
         hit |=> rd_valid);
   end else begin : g_comb
      assign rd_valid = hit;
      assign rd_data  = dat_i;
   end
endmodule

// File: rtl/blk_pipe_master.sv
module blk_pipe_master #(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int CW      = 8,
   parameter int MAX_OUT = 4,
   parameter bit RD_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [AW-1:0]    cmd_addr,
   input  logic             cmd_write,
   input  logic [DW/8-1:0]  cmd_sel,
   input  logic [CW-1:0]    cmd_count,
   input  logic [DW-1:0]    wr_data,
   output logic             wr_take,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   output logic             done,
   output logic [AW-1:0]    wb_adr_o,
   output logic [DW-1:0]    wb_dat_o,
   output logic             wb_we_o,
   output logic [DW/8-1:0]  wb_sel_o,
   output logic             wb_stb_o,
   output logic             wb_cyc_o,
   input  logic [DW-1:0]    wb_dat_i,
   input  logic             wb_ack_i,
   input  logic             wb_stall_i
);
   localparam int SW = DW / 8;

   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("DW must be a nonzero multiple of 8");
   end
   if (MAX_OUT < 1) begin : g_bad_max
      $error("MAX_OUT must be at least 1");
   end
   if (CW < 1 || AW < 1) begin : g_bad_w
      $error("CW and AW must be at least 1");
   end

   logic start, accept, all_issued, room, ack_ok;

   assign cmd_ready = ~wb_cyc_o;
   assign start     = cmd_valid & cmd_ready & (cmd_count != '0);

   bm_issue #(.AW(AW), .DW(DW), .SW(SW), .CW(CW)) i_issue (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_sel(cmd_sel),
      .cmd_count(cmd_count), .wr_data(wr_data), .stall_i(wb_stall_i),
      .room(room), .stb_o(wb_stb_o), .adr_o(wb_adr_o), .dat_o(wb_dat_o),
      .we_o(wb_we_o), .sel_o(wb_sel_o), .accept(accept),
      .all_issued(all_issued), .wr_take(wr_take)
   );

   bm_track #(.MAX_OUT(MAX_OUT)) i_track (
      .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
      .ack_i(wb_ack_i), .all_issued(all_issued), .room(room),
      .ack_ok(ack_ok), .cyc_o(wb_cyc_o), .done_o(done)
   );

   bm_rdcap #(.DW(DW), .REG_OUT(RD_REG)) i_rdcap (
      .clk(clk), .rst_n(rst_n), .ack_ok(ack_ok), .we(wb_we_o),
      .dat_i(wb_dat_i), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   p_stb_inside_cyc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wb_stb_o |-> wb_cyc_o);

   p_open_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (wb_cyc_o && wb_stb_o));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_zero_count_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_count == '0) |=> !wb_cyc_o);
endmodule

// File: tb/test_blk_pipe_master.sv
module test_blk_pipe_master;
   localparam int CLK_P   = 10;
   localparam int AW      = 16;
   localparam int DW      = 32;
   localparam int CW      = 5;
   localparam int MAX_OUT = 3;
   localparam int SW      = DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic cmd_ready;
   logic [AW-1:0] cmd_addr = '0;
   logic cmd_write = 1'b0;
   logic [SW-1:0] cmd_sel = '0;
   logic [CW-1:0] cmd_count = '0;
   logic [DW-1:0] wr_data = '0;
   logic wr_take, rd_valid, done;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] wb_adr_o;
   logic [DW-1:0] wb_dat_o;
   logic wb_we_o, wb_stb_o, wb_cyc_o;
   logic [SW-1:0] wb_sel_o;
   logic [DW-1:0] wb_dat_i = '0;
   logic wb_ack_i = 1'b0;
   logic wb_stall_i = 1'b0;

   int checks = 0;
   int errors = 0;
   int ncyc = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   blk_pipe_master #(.AW(AW), .DW(DW), .CW(CW), .MAX_OUT(MAX_OUT), .RD_REG(1'b1))
   i_blk_pipe_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_sel(cmd_sel),
      .cmd_count(cmd_count), .wr_data(wr_data), .wr_take(wr_take),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
      .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_we_o(wb_we_o),
      .wb_sel_o(wb_sel_o), .wb_stb_o(wb_stb_o), .wb_cyc_o(wb_cyc_o),
      .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i), .wb_stall_i(wb_stall_i)
   );

   function automatic logic [DW-1:0] wpat(input int txn, input int k);
      return (32'h9E37_79B9 * (txn + 1)) ^ (32'h0101_0101 * k) ^ 32'h0000_5A00;
   endfunction

   function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
      return ({16'h0, a} * 32'h0001_0003) ^ 32'hC3C3_0000;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      ncyc++;
   endtask

   int txn_id = 0;

   task automatic run_txn(input bit we, input logic [AW-1:0] start,
                          input int cnt, input logic [SW-1:0] sel,
                          input int stall_pct, input int ack_pct);
      logic [AW-1:0] pq[$];
      logic [DW-1:0] exp_rd = '0;
      bit exp_rv = 1'b0;
      int acc = 0;
      bit prev_stall = 1'b0;
      logic [AW-1:0] s_adr = '0;
      logic [DW-1:0] s_dat = '0;
      int guard = 0;
      bit acc_now;
      txn_id++;
      cmd_valid = 1'b1; cmd_addr = start; cmd_write = we; cmd_sel = sel;
      cmd_count = CW'(cnt); wr_data = wpat(txn_id, 0);
      wb_ack_i = 1'b0; wb_stall_i = 1'b0;
      tick();
      cmd_valid = 1'b0;
      forever begin
         // read return from previous acknowledge (R7)
         chk(rd_valid == exp_rv, "R7 rd_valid", 32'(rd_valid), 32'(exp_rv));
         if (exp_rv) chk(rd_data == exp_rd, "R7 rd_data", rd_data, exp_rd);
         if (acc == cnt && pq.size() == 0) begin
            chk(!wb_cyc_o && !wb_stb_o, "R6 cyc closes after last ack",
                32'(wb_cyc_o), 32'h0);
            chk(done, "R9 done pulse at close", 32'(done), 32'h1);
            chk(cmd_ready, "R6 cmd_ready when idle", 32'(cmd_ready), 32'h1);
            wb_ack_i = 1'b0; wb_stall_i = 1'b0;
            tick();
            chk(!done && !rd_valid, "R9 done lasts one clock",
                32'(done), 32'h0);
            break;
         end
         chk(wb_cyc_o && !cmd_ready, "R6 cyc held while pending",
             32'(wb_cyc_o), 32'h1);
         chk(!done, "R9 no done while open", 32'(done), 32'h0);
         chk(pq.size() <= MAX_OUT, "R8 outstanding bound", 32'(pq.size()),
             32'(MAX_OUT));
         chk(wb_stb_o == (acc < cnt && pq.size() < MAX_OUT),
             acc == 0 ? "R2 stb with first phase" : "R3 R5 R8 stb level",
             32'(wb_stb_o), 32'(acc < cnt && pq.size() < MAX_OUT));
         if (wb_stb_o) begin
            if (prev_stall)
               chk(wb_adr_o == s_adr && wb_dat_o == s_dat, "R4 stalled phase repeats",
                   32'(wb_adr_o), 32'(s_adr));
            chk(wb_adr_o == start + AW'(acc), acc == 0 ? "R2 start address" : "R3 address step",
                32'(wb_adr_o), 32'(start + AW'(acc)));
            chk(wb_we_o == we && wb_sel_o == sel, "R2 R4 we and sel",
                {wb_we_o, wb_sel_o}, {we, sel});
            if (we) chk(wb_dat_o == wpat(txn_id, acc), "R10 write word",
                        wb_dat_o, wpat(txn_id, acc));
         end
         // slave acknowledge, in order
         wb_ack_i = 1'b0; exp_rv = 1'b0;
         if (pq.size() > 0 && ($urandom % 100) < ack_pct) begin
            logic [AW-1:0] a;
            a = pq.pop_front();
            wb_ack_i = 1'b1;
            wb_dat_i = we ? $urandom : mem_val(a);
            exp_rv = !we; exp_rd = mem_val(a);
         end
         wb_stall_i = (($urandom % 100) < stall_pct);
         acc_now = wb_stb_o && !wb_stall_i;
         prev_stall = wb_stb_o && wb_stall_i;
         s_adr = wb_adr_o; s_dat = wb_dat_o;
         if (acc_now) begin
            pq.push_back(wb_adr_o);
            acc++;
            wr_data = wpat(txn_id, acc);
         end
         #1;
         chk(wr_take == (we && acc_now && acc < cnt), "R10 wr_take",
             32'(wr_take), 32'(we && acc_now && acc < cnt));
         tick();
         guard++;
         if (guard > 3000 || ncyc > 150000) begin
            chk(1'b0, "watchdog", 32'(guard), 32'h0);
            break;
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk(!wb_cyc_o && !wb_stb_o && !done && !wr_take && !rd_valid,
          "R1 idle after reset", {wb_cyc_o, wb_stb_o, done, wr_take, rd_valid}, 32'h0);
      chk(cmd_ready, "R1 cmd_ready after reset", 32'(cmd_ready), 32'h1);

      // R11: zero-length command
      cmd_valid = 1'b1; cmd_count = '0; cmd_write = 1'b1; cmd_addr = 16'h0040;
      tick();
      cmd_valid = 1'b0;
      chk(!wb_cyc_o && !wb_stb_o, "R11 zero count ignored",
          {wb_cyc_o, wb_stb_o}, 32'h0);
      tick();
      chk(!wb_cyc_o && !done, "R11 still idle", {wb_cyc_o, done}, 32'h0);

      run_txn(1'b0, 16'h0100, 6, 4'hF, 0, 100);   // R3 back-to-back reads
      run_txn(1'b1, 16'h0200, 5, 4'h3, 60, 100);  // R4 stalls on writes
      run_txn(1'b0, 16'h0300, 9, 4'hC, 0, 10);    // R8 slow slave hits cap
      run_txn(1'b1, 16'h0400, 1, 4'h1, 0, 50);    // single phase
      run_txn(1'b1, 16'hFFFE, 4, 4'hF, 30, 20);   // address wrap, cap on writes
      for (int i = 0; i < 30 && ncyc < 150000; i++) begin
         run_txn(1'($urandom), 16'($urandom), 1 + ($urandom % 31),
                 4'($urandom), $urandom % 70, 15 + ($urandom % 86));
      end
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 190000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule